// File: doc/BRIEF.md
# Segmented address translation unit

This block turns each memory reference issued by a user process into a physical address using a four-entry on-chip segment table. The top two bits of the virtual address pick a segment. The remaining thirty bits form an offset. That offset is checked against the segment's limit and against its read and write permissions, and then added to the segment's base. A reference made in kernel mode skips the table entirely: its address passes through as the physical address and it is never checked.

Supervisor code fills the table through a separate programming port. Each write of that port carries its own privilege bit. A write attempted without kernel privilege leaves the table untouched and raises a one-cycle privilege fault pulse. The result of every request appears one clock later. It consists of a valid strobe and a fault flag. A fault carries a cause code and zeroes the physical address. A fault that follows here, such as an exception, is handled by logic outside this block.

Top module: `seg_xlate`

## Requirements
- R1: A request with `req_kernel`=1 returns `rsp_paddr` equal to `req_vaddr`, with `rsp_fault`=0 and `rsp_cause`=0, whatever the table holds.
- R2: A user request (`req_kernel`=0) selects segment `req_vaddr[31:30]` and offset `req_vaddr[29:0]`. When every check passes, `rsp_paddr` equals the segment base plus the zero-extended offset, modulo 2^32.
- R3: A user request whose offset is greater than or equal to the segment limit faults with cause 1 (out of bounds). An offset of limit-1 is accepted, and a limit of 0 rejects every offset.
- R4: A user read (`req_write`=0) needs the segment's read permission bit, and a user write (`req_write`=1) needs its write permission bit. Otherwise the request faults with cause 2 (permission denied).
- R5: A user request to a segment whose valid bit is 0 faults with cause 0 (invalid segment). Reset clears every valid bit.
- R6: When several checks fail, the reported cause is the first in this order: invalid segment (0), then out of bounds (1), then permission denied (2). Cause 3 never appears.
- R7: The response is registered. `rsp_valid` in a cycle equals `req_valid` one cycle earlier. On a fault `rsp_paddr` is 0. Without a fault `rsp_cause` is 0. In a cycle with no response, all response outputs are 0, and all are 0 after reset.
- R8: A table write (`cfg_we`=1) changes the table only when `cfg_kernel`=1. With `cfg_kernel`=0 the table keeps its contents, and `cfg_priv_fault` is 1 in the next cycle only.
- R9: Take a table where segment 0 has base 0x2000, limit 0x6ff and read only, segment 1 has base 0, limit 0x4ff and read/write, segment 2 has base 0x3000, limit 0xfff and read/write, and segment 3 has limit 0 and no permissions. Reads then map 0x00000240 to 0x2240, 0x40000108 to 0x108 and 0x8000065c to 0x365c, and every access to segment 3 faults.
- R10: A request in the same cycle as a table write is translated with the table contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 32 | Virtual address: segment in bits 31:30, offset in bits 29:0 |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_kernel | input | 1 | 1 = kernel mode (pass-through), 0 = user mode |
| cfg_we | input | 1 | Table write strobe |
| cfg_kernel | input | 1 | Privilege of the table write (1 = kernel) |
| cfg_idx | input | 2 | Segment entry to write |
| cfg_base | input | 32 | New base |
| cfg_limit | input | 32 | New limit (offsets must be below it) |
| cfg_rd_ok | input | 1 | New read permission |
| cfg_wr_ok | input | 1 | New write permission |
| cfg_valid | input | 1 | New valid bit |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 2 | 0 invalid segment, 1 out of bounds, 2 permission denied |
| cfg_priv_fault | output | 1 | Pulse: previous table write lacked kernel privilege |

## Verification
The assertions check on every cycle the one-cycle response timing, the kernel pass-through, the zero address and legal cause on faults, and that a table write without privilege changes none of the valid or permission bits. Several behaviours can only be shown by the bench's scenarios: the correct base plus offset sum, the bound at limit-1 against limit, the cause chosen when checks fail together, the sample table, and the fact that a request sees the table from before a write in the same cycle. These scenarios are directed cases together with a random mix, and the bench compares each response against its own model of the table.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int ADDR_W   = 32,
  parameter int SEG_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  input  logic              req_kernel,
  input  logic              cfg_we,
  input  logic              cfg_kernel,
  input  logic [SEG_BITS-1:0] cfg_idx,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_limit,
  input  logic              cfg_rd_ok,
  input  logic              cfg_wr_ok,
  input  logic              cfg_valid,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_fault,
  output logic [1:0]        rsp_cause,
  output logic              cfg_priv_fault
);

  localparam int NSEG  = 1 << SEG_BITS;
  localparam int OFF_W = ADDR_W - SEG_BITS;
  localparam logic [1:0] C_NOSEG = 2'd0;
  localparam logic [1:0] C_BOUND = 2'd1;
  localparam logic [1:0] C_PERM  = 2'd2;

  logic [ADDR_W-1:0] base_q [NSEG];
  logic [ADDR_W-1:0] lim_q  [NSEG];
  logic [NSEG-1:0]   vld_q, rd_q, wr_q;

  wire [SEG_BITS-1:0] seg = req_vaddr[ADDR_W-1 -: SEG_BITS];
  wire [ADDR_W-1:0]   off = {{SEG_BITS{1'b0}}, req_vaddr[OFF_W-1:0]};

  wire miss    = !vld_q[seg];
  wire oob     = off >= lim_q[seg];
  wire no_perm = req_write ? !wr_q[seg] : !rd_q[seg];

  logic              n_fault;
  logic [1:0]        n_cause;
  logic [ADDR_W-1:0] n_paddr;

  always_comb begin
    n_fault = 1'b0;
    n_cause = C_NOSEG;
    n_paddr = '0;
    if (req_kernel) begin
      n_paddr = req_vaddr;
    end else if (miss) begin
      n_fault = 1'b1;
      n_cause = C_NOSEG;
    end else if (oob) begin
      n_fault = 1'b1;
      n_cause = C_BOUND;
    end else if (no_perm) begin
      n_fault = 1'b1;
      n_cause = C_PERM;
    end else begin
      n_paddr = base_q[seg] + off;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rd_q  <= '0;
      wr_q  <= '0;
      for (int i = 0; i < NSEG; i++) begin
        base_q[i] <= '0;
        lim_q[i]  <= '0;
      end
    end else if (cfg_we && cfg_kernel) begin
      vld_q[cfg_idx]  <= cfg_valid;
      rd_q[cfg_idx]   <= cfg_rd_ok;
      wr_q[cfg_idx]   <= cfg_wr_ok;
      base_q[cfg_idx] <= cfg_base;
      lim_q[cfg_idx]  <= cfg_limit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_fault      <= 1'b0;
      rsp_cause      <= C_NOSEG;
      rsp_paddr      <= '0;
      cfg_priv_fault <= 1'b0;
    end else begin
      rsp_valid      <= req_valid;
      rsp_fault      <= req_valid && n_fault;
      rsp_cause      <= req_valid ? n_cause : C_NOSEG;
      rsp_paddr      <= req_valid ? n_paddr : '0;
      cfg_priv_fault <= cfg_we && !cfg_kernel;
    end
  end

  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !rsp_fault && rsp_paddr == '0);
  a_r1_kernel_pass: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kernel |=> !rsp_fault && rsp_paddr == $past(req_vaddr));
  a_r7_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_valid && rsp_paddr == '0);
  a_r6_cause_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_cause != 2'd3);
  a_r7_clean_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_fault |-> rsp_cause == C_NOSEG);
  a_r8_user_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && !cfg_kernel |=> cfg_priv_fault && $stable(vld_q) && $stable(rd_q) && $stable(wr_q));
  a_r8_pulse_only: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && !cfg_kernel) |=> !cfg_priv_fault);

endmodule

// File: tb/seg_xlate_tb_top.sv
`timescale 1ns/1ps
module seg_xlate_tb_top;
  localparam time CYC = 20ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_kernel = 0;
  logic [31:0] req_vaddr = '0;
  logic cfg_we = 0, cfg_kernel = 0, cfg_rd_ok = 0, cfg_wr_ok = 0, cfg_valid = 0;
  logic [1:0] cfg_idx = '0;
  logic [31:0] cfg_base = '0, cfg_limit = '0;
  logic rsp_valid, rsp_fault, cfg_priv_fault;
  logic [1:0] rsp_cause;
  logic [31:0] rsp_paddr;

  int checks = 0, errors = 0;

  logic [31:0] m_base [4], m_lim [4];
  logic m_v [4], m_r [4], m_w [4];

  always #(CYC/2) clk = ~clk;

  seg_xlate dut_i (
    .clk, .rst_n, .req_valid, .req_vaddr, .req_write, .req_kernel,
    .cfg_we, .cfg_kernel, .cfg_idx, .cfg_base, .cfg_limit,
    .cfg_rd_ok, .cfg_wr_ok, .cfg_valid,
    .rsp_valid, .rsp_paddr, .rsp_fault, .rsp_cause, .cfg_priv_fault
  );

  function automatic logic [34:0] xlate(logic [31:0] a, logic w, logic k);
    logic [1:0] s;
    logic [31:0] o;
    if (k) return {1'b0, 2'd0, a};
    s = a[31:30];
    o = {2'b00, a[29:0]};
    if (!m_v[s]) return {1'b1, 2'd0, 32'd0};
    if (o >= m_lim[s]) return {1'b1, 2'd1, 32'd0};
    if (w ? !m_w[s] : !m_r[s]) return {1'b1, 2'd2, 32'd0};
    return {1'b0, 2'd0, m_base[s] + o};
  endfunction

  task automatic check(input string tag, input logic [34:0] act, input logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got fault=%0b cause=%0d paddr=%h, expected fault=%0b cause=%0d paddr=%h",
               tag, act[34], act[33:32], act[31:0], exp[34], exp[33:32], exp[31:0]);
    end
  endtask

  task automatic cycle(input logic dr, input logic [31:0] a, input logic w, input logic k,
                       input logic dc, input logic ck, input logic [1:0] idx,
                       input logic [31:0] b, input logic [31:0] l,
                       input logic r_ok, input logic w_ok, input logic v, input string tag);
    logic [34:0] exp;
    exp = dr ? xlate(a, w, k) : 35'd0;
    req_valid = dr; req_vaddr = a; req_write = w; req_kernel = k;
    cfg_we = dc; cfg_kernel = ck; cfg_idx = idx; cfg_base = b; cfg_limit = l;
    cfg_rd_ok = r_ok; cfg_wr_ok = w_ok; cfg_valid = v;
    @(negedge clk);
    req_valid = 0; cfg_we = 0;
    check({tag, " R7 valid"}, {34'd0, rsp_valid}, {34'd0, dr});
    check(tag, {rsp_fault, rsp_cause, rsp_paddr}, exp);
    check({tag, " R8 priv"}, {34'd0, cfg_priv_fault}, {34'd0, dc && !ck});
    if (dc && ck) begin
      m_base[idx] = b; m_lim[idx] = l; m_r[idx] = r_ok; m_w[idx] = w_ok; m_v[idx] = v;
    end
  endtask

  task automatic rq(input logic [31:0] a, input logic w, input logic k, input string tag);
    cycle(1, a, w, k, 0, 0, 2'd0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic wr(input logic ck, input logic [1:0] idx, input logic [31:0] b,
                    input logic [31:0] l, input logic r_ok, input logic w_ok,
                    input logic v, input string tag);
    cycle(0, 0, 0, 0, 1, ck, idx, b, l, r_ok, w_ok, v, tag);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CYC * 20000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_2024));
    for (int i = 0; i < 4; i++) begin
      m_base[i] = 0; m_lim[i] = 0; m_v[i] = 0; m_r[i] = 0; m_w[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 reset outputs", {rsp_fault, rsp_cause, rsp_paddr}, 35'd0);
    check("R7 reset valid", {34'd0, rsp_valid}, 35'd0);

    rq(32'hDEAD_BEEF, 1, 1, "R1 kernel passthrough");
    rq(32'h4000_0108, 0, 0, "R5 invalid after reset");
    rq(32'hC000_0000, 1, 0, "R5 invalid seg3 after reset");

    wr(1, 2'd0, 32'h2000, 32'h6ff, 1, 0, 1, "R9 program seg0");
    wr(1, 2'd1, 32'h0000, 32'h4ff, 1, 1, 1, "R9 program seg1");
    wr(1, 2'd2, 32'h3000, 32'hfff, 1, 1, 1, "R9 program seg2");
    wr(1, 2'd3, 32'h0000, 32'h000, 0, 0, 1, "R9 program seg3");
    rq(32'h0000_0240, 0, 0, "R9 seg0 0x240");
    rq(32'h4000_0108, 0, 0, "R9 seg1 0x108");
    rq(32'h8000_065c, 0, 0, "R9 seg2 0x65c");
    rq(32'hC000_0010, 0, 0, "R9 seg3 faults");
    rq(32'h8000_065c, 1, 0, "R2 seg2 write");
    rq(32'h0000_0240, 1, 0, "R4 write to read-only");
    rq(32'hDEAD_BEEF, 0, 1, "R1 kernel ignores table");

    rq(32'h4000_04fe, 0, 0, "R3 offset limit-1");
    rq(32'h4000_04ff, 0, 0, "R3 offset equals limit");
    rq(32'h7FFF_FFFF, 1, 0, "R3 offset max");
    rq(32'hC000_0000, 1, 0, "R6 bound before perm");
    wr(1, 2'd2, 32'h3000, 32'hfff, 0, 0, 0, "R6 invalidate seg2");
    rq(32'hBFFF_FFFF, 1, 0, "R6 invalid before bound/perm");
    wr(1, 2'd0, 32'h2000, 32'h6ff, 0, 0, 1, "R4 seg0 no read");
    rq(32'h0000_0100, 0, 0, "R4 read denied");
    wr(1, 2'd0, 32'h2000, 32'h6ff, 1, 0, 1, "R4 seg0 read back");

    wr(0, 2'd0, 32'h9000, 32'hffff, 1, 1, 1, "R8 user write");
    rq(32'h0000_0240, 0, 0, "R8 table unchanged");
    rq(32'h0000_0240, 1, 0, "R8 perms unchanged");

    cycle(1, 32'h4000_0108, 0, 0, 1, 1, 2'd1, 32'h5000, 32'h4ff, 1, 1, 1, "R10 same-cycle old table");
    rq(32'h4000_0108, 0, 0, "R10 new table");
    rq(32'hFFFF_FFF0, 0, 1, "R1 kernel high address");

    for (int n = 0; n < 600; n++) begin
      logic [31:0] a;
      logic dr, dc;
      dr = ($urandom % 4) != 0;
      dc = ($urandom % 5) == 0;
      a = {$urandom % 4, 30'($urandom % 32'h2000)};
      if (($urandom % 8) == 0) a = $urandom;
      cycle(dr, a, 1'($urandom), ($urandom % 5) == 0,
            dc, ($urandom % 4) != 0, 2'($urandom),
            $urandom, $urandom % 32'h2000,
            1'($urandom), 1'($urandom), ($urandom % 4) != 0,
            "R2 R3 R4 R6 R10 random");
    end
    finish_run();
  end
endmodule